// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block discovers which parallel NOR flash device sits on a byte-wide bus. After a start pulse it waits out a settling delay and puts the device into a known read state. It then issues the three-write unlock-and-identify command, reads the manufacturer and device codes, and takes the device back out of identification mode. Finally it reads the same two locations again. A code byte of 0x7F is a continuation marker: the byte at the paired continuation offset is then appended below it, which gives a 16-bit code. Otherwise the code is the byte zero-extended to 16 bits.

The host supplies:
- the expected manufacturer and device codes;
- which command-address mask the device decodes;
- whether the reset is the plain single write or the unlock-prefixed form;
- a timing mode, which selects caller-given delays, no delays or built-in defaults.

When the run ends, `done` pulses for one cycle. At that point `match` reports whether both codes equal the expected pair. Three warnings are also reported: the manufacturer code's low byte fails odd parity, or a code read in identification mode is identical to what the array returns after exit (the device probably never entered identification mode). An invalid mask or timing selection ends the run at once with `err` set and no bus traffic. The bus is a simple request/acknowledge master: one byte access per acknowledge.

Top module: `flash_id_probe`

## Requirements
- R1: A start with `mask_sel` = 3 or `timing_mode` = 3 makes no bus access. `done` pulses with `err` = 1 and `match` = 0.
- R2: After a valid start, the first bus access comes no earlier than the effective enter delay, counted in clock cycles.
- R3: The reset step writes 0xF0 to 0x5555&M. With `long_reset` = 1 it is preceded by 0xAA to 0x5555&M and 0x55 to 0x2AAA&M. M is 0xFFFF for `mask_sel` 0, 0x07FF for 1 and 0x0FFF for 2.
- R4: The entry step writes 0xAA to 0x5555&M, 0x55 to 0x2AAA&M and 0x90 to 0x5555&M. The first read follows the 0x90 write by at least the enter delay. The exit step repeats the reset step of R3, and the next write after a 0xF0 comes at least the exit delay later.
- R5: Between the writes of one step there are at least GAP_CYC cycles whenever that step's delay (enter for entry, exit for reset/exit) is non-zero.
- R6: Codes are read at offset 0 (manufacturer) and 1 (device). A byte of 0x7F takes a second byte from 0x100 or 0x101 and forms {0x7F, byte}; any other byte gives {0x00, byte}.
- R7: `par_warn` is 1 when the low byte of the manufacturer code has an even number of ones.
- R8: After exit, offsets 0 and 1 are re-read with the R6 rule. `alias_mfr` and `alias_dev` are 1 when the re-read code equals the identification code.
- R9: `done` is high for exactly one cycle per start. `match` is 1 only when both codes equal `exp_mfr` and `exp_dev`.
- R10: `timing_mode` 0 uses `enter_dly`/`exit_dly`, 1 uses zero delays and no gaps, and 2 uses DEF_ENTER (10000) and DEF_EXIT (40).
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay unchanged.
- R12: After reset, `busy`, `done`, `err`, `match` and `bus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted while idle |
| exp_mfr | input | 16 | Expected manufacturer code |
| exp_dev | input | 16 | Expected device code |
| mask_sel | input | 2 | Command address mask select |
| long_reset | input | 1 | Use the unlock-prefixed reset |
| timing_mode | input | 2 | 0 given, 1 zero, 2 default, 3 invalid |
| enter_dly | input | DLY_W | Enter delay in cycles (mode 0) |
| exit_dly | input | DLY_W | Exit delay in cycles (mode 0) |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Access byte address |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Access completed |
| bus_rdata | input | 8 | Read byte, valid with ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Configuration rejected |
| match | output | 1 | Both codes equal the expected pair |
| par_warn | output | 1 | Manufacturer parity warning |
| alias_mfr | output | 1 | Manufacturer code equals array content |
| alias_dev | output | 1 | Device code equals array content |
| mfr_code | output | 16 | Manufacturer code read |
| dev_code | output | 16 | Device code read |

## Verification
A small device model on the bus answers from an identification table while in identification mode and from array content otherwise. Its patterns are:
- plain codes, which pin the basic read path;
- continuation codes on one or both sides, which separate the 0x7F handling from plain zero-extension;
- an even-parity manufacturer byte, which shows the parity flag is wired up;
- a near-miss device code, which shows that `match` compares the full 16 bits;
- a device that ignores the identify command, which forces both alias flags;
- array content equal to one code only, which shows the two alias flags are independent.

Each pattern runs under a different mask and reset form, so the logged write sequence tells the three masks and both reset lengths apart. Timed runs in given and default modes measure the waits before the first access, after the identify write and after each reset write, plus the minimum gap between writes. Invalid selections are checked for zero bus traffic.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 16;

  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_ID_ON  = 8'h90;
  localparam logic [7:0] CMD_RST    = 8'hF0;
  localparam logic [7:0] CONT_MARK  = 8'h7F;

  localparam logic [15:0] CMD_ADR_A = 16'h5555;
  localparam logic [15:0] CMD_ADR_B = 16'h2AAA;
  localparam logic [15:0] RD_MFR    = 16'h0000;
  localparam logic [15:0] RD_DEV    = 16'h0001;
  localparam logic [15:0] RD_MFR_X  = 16'h0100;
  localparam logic [15:0] RD_DEV_X  = 16'h0101;

  typedef enum logic [3:0] {
    PS_IDLE, PS_WAIT,
    PS_RST_A, PS_RST_B, PS_RST_F,
    PS_ENT_A, PS_ENT_B, PS_ENT_C,
    PS_RD_M, PS_RD_MX, PS_RD_D, PS_RD_DX,
    PS_FIN
  } pstate_t;

  typedef enum logic [1:0] {
    TM_GIVEN = 2'd0, TM_ZERO = 2'd1, TM_DEFAULT = 2'd2, TM_BAD = 2'd3
  } tmode_t;

  function automatic logic [15:0] mask_for(input logic [1:0] sel);
    case (sel)
      2'd0:    mask_for = 16'hFFFF;
      2'd1:    mask_for = 16'h07FF;
      2'd2:    mask_for = 16'h0FFF;
      default: mask_for = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/probe_delay_timer.sv
module probe_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R5
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/probe_code_reg.sv
module probe_code_reg
  import flash_probe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_first,
  input  logic              cap_cont,
  input  logic [BYTE_W-1:0] din,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code;
    if (clr)            code_d = '0;
    else if (cap_first) code_d = {{(CODE_W-BYTE_W){1'b0}}, din};
    else if (cap_cont)  code_d = {code[BYTE_W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= code_d;
  end

  // R6
  cont_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_cont && !clr) |=> (code[CODE_W-1:BYTE_W] == CONT_MARK));

endmodule

// File: rtl/probe_verdict.sv
module probe_verdict
  import flash_probe_pkg::*;
(
  input  logic [CODE_W-1:0] id_m,
  input  logic [CODE_W-1:0] id_d,
  input  logic [CODE_W-1:0] rr_m,
  input  logic [CODE_W-1:0] rr_d,
  input  logic [CODE_W-1:0] want_m,
  input  logic [CODE_W-1:0] want_d,
  output logic              hit,
  output logic              par_bad,
  output logic              same_m,
  output logic              same_d
);
  assign hit     = (id_m == want_m) && (id_d == want_d);
  assign par_bad = ~(^id_m[BYTE_W-1:0]);
  assign same_m  = (id_m == rr_m);
  assign same_d  = (id_d == rr_d);
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DLY_W     = 16,
  parameter int GAP_CYC   = 10,
  parameter int DEF_ENTER = 10000,
  parameter int DEF_EXIT  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       exp_mfr,
  input  logic [15:0]       exp_dev,
  input  logic [1:0]        mask_sel,
  input  logic              long_reset,
  input  logic [1:0]        timing_mode,
  input  logic [DLY_W-1:0]  enter_dly,
  input  logic [DLY_W-1:0]  exit_dly,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              match,
  output logic              par_warn,
  output logic              alias_mfr,
  output logic              alias_dev,
  output logic [15:0]       mfr_code,
  output logic [15:0]       dev_code
);
  localparam int NSLOT = 4;
  localparam logic [DLY_W-1:0] GAP_V = DLY_W'(GAP_CYC);
  localparam logic [DLY_W-1:0] DEF_E = DLY_W'(DEF_ENTER);
  localparam logic [DLY_W-1:0] DEF_X = DLY_W'(DEF_EXIT);

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  pstate_t st_q, st_d, ret_q, ret_d;
  logic ph_q, ph_d, err_d;
  logic long_q;
  logic [15:0] mask_q;
  logic [15:0] wm_q, wd_q;
  logic [DLY_W-1:0] dent_q, dext_q, gent_q, gext_q;
  logic [DLY_W-1:0] eff_ent, eff_ext;
  logic cfg_ok, cfg_en, fin_en;
  logic tmr_load, tmr_zero;
  logic [DLY_W-1:0] tmr_val;
  logic [NSLOT-1:0] cap_f, cap_c;
  logic [15:0] code_w [NSLOT];
  logic v_hit, v_par, v_sm, v_sd;
  logic done_q, err_q, match_q, par_q, am_q, ad_q;

  tmode_t tmode;
  assign tmode  = tmode_t'(timing_mode);
  assign cfg_ok = (mask_sel != 2'd3) && (tmode != TM_BAD);
  assign cfg_en = (st_q == PS_IDLE) && start;
  assign fin_en = (st_q == PS_FIN);

  always_comb begin
    case (tmode)
      TM_GIVEN:   begin eff_ent = enter_dly; eff_ext = exit_dly; end
      TM_DEFAULT: begin eff_ent = DEF_E;     eff_ext = DEF_X;    end
      default:    begin eff_ent = '0;        eff_ext = '0;       end
    endcase
  end

  // next state
  always_comb begin
    st_d = st_q; ret_d = ret_q; ph_d = ph_q; err_d = err_q;
    tmr_load = 1'b0; tmr_val = '0;
    cap_f = '0; cap_c = '0;
    unique case (st_q)
      PS_IDLE: if (start) begin
        if (!cfg_ok) begin
          err_d = 1'b1; st_d = PS_FIN;
        end else begin
          err_d = 1'b0; ph_d = 1'b0;
          tmr_load = 1'b1; tmr_val = eff_ent;
          ret_d = long_reset ? PS_RST_A : PS_RST_F;
          st_d = PS_WAIT;
        end
      end
      PS_WAIT: if (tmr_zero) st_d = ret_q;
      PS_RST_A: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = gext_q; ret_d = PS_RST_B; st_d = PS_WAIT;
      end
      PS_RST_B: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = gext_q; ret_d = PS_RST_F; st_d = PS_WAIT;
      end
      PS_RST_F: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = dext_q;
        ret_d = ph_q ? PS_RD_M : PS_ENT_A; st_d = PS_WAIT;
      end
      PS_ENT_A: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = gent_q; ret_d = PS_ENT_B; st_d = PS_WAIT;
      end
      PS_ENT_B: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = gent_q; ret_d = PS_ENT_C; st_d = PS_WAIT;
      end
      PS_ENT_C: if (bus_ack) begin
        tmr_load = 1'b1; tmr_val = dent_q; ret_d = PS_RD_M; st_d = PS_WAIT;
      end
      PS_RD_M: if (bus_ack) begin
        cap_f[{ph_q, 1'b0}] = 1'b1;
        st_d = (bus_rdata == CONT_MARK) ? PS_RD_MX : PS_RD_D;
      end
      PS_RD_MX: if (bus_ack) begin
        cap_c[{ph_q, 1'b0}] = 1'b1; st_d = PS_RD_D;
      end
      PS_RD_D, PS_RD_DX: if (bus_ack) begin
        if (st_q == PS_RD_D) cap_f[{ph_q, 1'b1}] = 1'b1;
        else                 cap_c[{ph_q, 1'b1}] = 1'b1;
        if (st_q == PS_RD_D && bus_rdata == CONT_MARK) st_d = PS_RD_DX;
        else if (ph_q) st_d = PS_FIN;
        else begin
          ph_d = 1'b1;
          st_d = long_q ? PS_RST_A : PS_RST_F;
        end
      end
      PS_FIN: st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q <= PS_IDLE; ret_q <= PS_IDLE; ph_q <= 1'b0; err_q <= 1'b0;
      long_q <= 1'b0; mask_q <= '0; wm_q <= '0; wd_q <= '0;
      dent_q <= '0; dext_q <= '0; gent_q <= '0; gext_q <= '0;
      done_q <= 1'b0; match_q <= 1'b0; par_q <= 1'b0; am_q <= 1'b0; ad_q <= 1'b0;
    end else begin
      st_q <= st_d; ret_q <= ret_d; ph_q <= ph_d; err_q <= err_d;
      done_q <= fin_en;
      if (cfg_en) begin
        long_q <= long_reset;
        mask_q <= mask_for(mask_sel);
        wm_q   <= exp_mfr;
        wd_q   <= exp_dev;
        dent_q <= eff_ent;
        dext_q <= eff_ext;
        gent_q <= (eff_ent != '0) ? GAP_V : '0;
        gext_q <= (eff_ext != '0) ? GAP_V : '0;
      end
      if (fin_en) begin
        match_q <= !err_q && v_hit;
        par_q   <= !err_q && v_par;
        am_q    <= !err_q && v_sm;
        ad_q    <= !err_q && v_sd;
      end
    end
  end

  probe_delay_timer #(.W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rs_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  // slot index = {after_exit, is_device}
  for (genvar g = 0; g < NSLOT; g++) begin : g_code
    probe_code_reg u_code (
      .clk(clk), .rst_n(rs_n), .clr(cfg_en),
      .cap_first(cap_f[g]), .cap_cont(cap_c[g]),
      .din(bus_rdata), .code(code_w[g])
    );
  end

  probe_verdict u_verdict (
    .id_m(code_w[0]), .id_d(code_w[1]), .rr_m(code_w[2]), .rr_d(code_w[3]),
    .want_m(wm_q), .want_d(wd_q),
    .hit(v_hit), .par_bad(v_par), .same_m(v_sm), .same_d(v_sd)
  );

  // bus drive
  logic [15:0] adr16;
  always_comb begin
    bus_req = 1'b1; bus_we = 1'b1; bus_wdata = 8'h00; adr16 = 16'h0000;
    case (st_q)
      PS_RST_A, PS_ENT_A: begin adr16 = CMD_ADR_A & mask_q; bus_wdata = CMD_UNLK_A; end
      PS_RST_B, PS_ENT_B: begin adr16 = CMD_ADR_B & mask_q; bus_wdata = CMD_UNLK_B; end
      PS_RST_F: begin adr16 = CMD_ADR_A & mask_q; bus_wdata = CMD_RST; end
      PS_ENT_C: begin adr16 = CMD_ADR_A & mask_q; bus_wdata = CMD_ID_ON; end
      PS_RD_M:  begin bus_we = 1'b0; adr16 = RD_MFR;   end
      PS_RD_MX: begin bus_we = 1'b0; adr16 = RD_MFR_X; end
      PS_RD_D:  begin bus_we = 1'b0; adr16 = RD_DEV;   end
      PS_RD_DX: begin bus_we = 1'b0; adr16 = RD_DEV_X; end
      default:  begin bus_req = 1'b0; bus_we = 1'b0; end
    endcase
  end

  assign bus_addr  = ADDR_W'(adr16);
  assign busy      = (st_q != PS_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign match     = match_q;
  assign par_warn  = par_q;
  assign alias_mfr = am_q;
  assign alias_dev = ad_q;
  assign mfr_code  = code_w[0];
  assign dev_code  = code_w[1];

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done);

  // R1
  err_nomatch_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (done && err) |-> !match);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rs_n)
    !busy |-> !bus_req);

endmodule

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;

  typedef struct packed {
    logic [1:0]  msel;
    logic        lng;
    logic        deaf;
    logic [7:0]  im0, im1, id0, id1, ar0, ar1;
    logic [15:0] em, ed, wm, wd;
    logic        wmatch, wpar, wam, wad;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'hBF, 8'h00, 8'hB5, 8'h00, 8'h12, 8'h34, 16'h00BF, 16'h00B5, 16'h00BF, 16'h00B5, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 8'h7F, 8'h9D, 8'h7F, 8'h21, 8'h12, 8'h34, 16'h7F9D, 16'h7F21, 16'h7F9D, 16'h7F21, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 8'hC2, 8'h00, 8'h7F, 8'h55, 8'h12, 8'h34, 16'h00C2, 16'h7F56, 16'h00C2, 16'h7F55, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 8'h03, 8'h00, 8'h40, 8'h00, 8'h12, 8'h34, 16'h0003, 16'h0040, 16'h0003, 16'h0040, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b1, 8'h11, 8'h22, 8'h33, 8'h44, 8'hDA, 8'h7F, 16'h00DA, 16'h7FC3, 16'h00DA, 16'h7FC3, 1'b1, 1'b0, 1'b1, 1'b1},
    '{2'd2, 1'b1, 1'b0, 8'hBF, 8'h00, 8'hB5, 8'h00, 8'hBF, 8'h35, 16'h00BF, 16'h00B5, 16'h00BF, 16'h00B5, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic [1:0] mask_sel = '0;
  logic long_reset = 1'b0;
  logic [1:0] timing_mode = 2'd1;
  logic [15:0] enter_dly = '0, exit_dly = '0;
  logic bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;
  logic busy, done, err, match, par_warn, alias_mfr, alias_dev;
  logic [15:0] mfr_code, dev_code;

  always #4 clk = ~clk;

  flash_id_probe i_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .mask_sel(mask_sel), .long_reset(long_reset), .timing_mode(timing_mode),
    .enter_dly(enter_dly), .exit_dly(exit_dly),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .err(err), .match(match), .par_warn(par_warn),
    .alias_mfr(alias_mfr), .alias_dev(alias_dev), .mfr_code(mfr_code), .dev_code(dev_code)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  vec_t cv;
  logic id_mode = 1'b0;
  int wr_n, rd_n, first_acc, last_wr_cyc, min_gap, f0_gap, ent_gap, start_cyc, done_cnt;
  logic [7:0] last_wr_data;
  logic [15:0] wr_a [16];
  logic [7:0]  wr_d [16];

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    if (id_mode) begin
      case (a)
        16'h0000: model_rd = cv.im0;
        16'h0100: model_rd = cv.im1;
        16'h0001: model_rd = cv.id0;
        16'h0101: model_rd = cv.id1;
        default:  model_rd = 8'hFF;
      endcase
    end else begin
      case (a)
        16'h0000: model_rd = cv.ar0;
        16'h0001: model_rd = cv.ar1;
        16'h0100: model_rd = 8'h3C;
        16'h0101: model_rd = 8'hC3;
        default:  model_rd = 8'hFF;
      endcase
    end
  endfunction

  // device model and timing monitor
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (bus_req && !bus_ack) begin
      if (first_acc < 0) first_acc = cyc - start_cyc;
      if (bus_we) begin
        if (wr_n > 0) begin
          if (cyc - last_wr_cyc < min_gap) min_gap = cyc - last_wr_cyc;
          if (last_wr_data == 8'hF0 && f0_gap < 0) f0_gap = cyc - last_wr_cyc;
        end
        if (wr_n < 16) begin wr_a[wr_n] = bus_addr; wr_d[wr_n] = bus_wdata; end
        wr_n++;
        last_wr_cyc = cyc;
        last_wr_data = bus_wdata;
        if (bus_wdata == 8'h90 && !cv.deaf) id_mode = 1'b1;
        if (bus_wdata == 8'hF0) id_mode = 1'b0;
      end else begin
        if (rd_n == 0 && last_wr_data == 8'h90) ent_gap = cyc - last_wr_cyc;
        rd_n++;
        bus_rdata = model_rd(bus_addr);
      end
      bus_ack = 1'b1;
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic run(input logic [1:0] ms, input logic lg, input logic [1:0] tm,
                     input int ent, input int ext, input logic [15:0] em, input logic [15:0] ed);
    @(negedge clk);
    wr_n = 0; rd_n = 0; first_acc = -1; min_gap = 1000000; f0_gap = -1; ent_gap = -1;
    done_cnt = 0; last_wr_data = 8'h00; id_mode = 1'b0;
    mask_sel = ms; long_reset = lg; timing_mode = tm;
    enter_dly = 16'(ent); exit_dly = 16'(ext); exp_mfr = em; exp_dev = ed;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    for (int k = 0; k < 40000 && done_cnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_seq(input logic [1:0] ms, input logic lg, input string req);
    logic [15:0] m, a5, a2;
    logic [15:0] ea [16];
    logic [7:0]  ed [16];
    int n, bad;
    m = (ms == 2'd0) ? 16'hFFFF : (ms == 2'd1) ? 16'h07FF : 16'h0FFF;
    a5 = 16'h5555 & m; a2 = 16'h2AAA & m;
    n = 0;
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin
        ea[n] = a5; ed[n] = 8'hAA; n++;
        ea[n] = a2; ed[n] = 8'h55; n++;
        ea[n] = a5; ed[n] = 8'h90; n++;
      end
      if (lg) begin
        ea[n] = a5; ed[n] = 8'hAA; n++;
        ea[n] = a2; ed[n] = 8'h55; n++;
      end
      ea[n] = a5; ed[n] = 8'hF0; n++;
    end
    // order above: reset, entry, exit
    begin
      logic [15:0] sa [16];
      logic [7:0]  sd [16];
      int q;
      int rl;
      rl = lg ? 3 : 1;
      q = 0;
      for (int i = 0; i < rl; i++) begin sa[q] = ea[i]; sd[q] = ed[i]; q++; end
      for (int i = rl + 3; i < rl + 3 + 3; i++) ;
      for (int i = rl; i < n; i++) begin sa[q] = ea[i]; sd[q] = ed[i]; q++; end
      bad = 0;
      if (wr_n != n) bad++;
      for (int i = 0; i < n && i < 16; i++)
        if (wr_a[i] != sa[i] || wr_d[i] != sd[i]) bad++;
    end
    chk(req, bad == 0, wr_n, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy == 1'b0, busy, 0);
    chk("R12 done/err/match", {done, err, match} == 3'b000, {done, err, match}, 0);
    chk("R12 bus_req", bus_req == 1'b0, bus_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of patterns, zero-delay mode
    for (int i = 0; i < NV; i++) begin
      cv = VECS[i];
      run(cv.msel, cv.lng, 2'd1, 0, 0, cv.em, cv.ed);
      check_seq(cv.msel, cv.lng, "R3 R4 command sequence");
      chk("R6 manufacturer code", mfr_code == cv.wm, mfr_code, cv.wm);
      chk("R6 device code", dev_code == cv.wd, dev_code, cv.wd);
      chk("R9 match", match == cv.wmatch, match, cv.wmatch);
      chk("R7 parity warning", par_warn == cv.wpar, par_warn, cv.wpar);
      chk("R8 alias flags", {alias_mfr, alias_dev} == {cv.wam, cv.wad}, {alias_mfr, alias_dev}, {cv.wam, cv.wad});
      chk("R9 single done pulse", done_cnt == 1 && err == 1'b0, done_cnt, 1);
    end

    // R10 zero mode runs quickly
    cv = VECS[0];
    run(2'd0, 1'b0, 2'd1, 500, 500, 16'h00BF, 16'h00B5);
    chk("R10 zero mode ignores delay inputs", first_acc < 5 && min_gap < 10, first_acc, 0);

    // R1 invalid mask select
    run(2'd3, 1'b0, 2'd1, 0, 0, 16'h00BF, 16'h00B5);
    chk("R1 bad mask no access", wr_n + rd_n == 0, wr_n + rd_n, 0);
    chk("R1 bad mask err", err == 1'b1 && match == 1'b0 && done_cnt == 1, {err, match}, 2'b10);

    // R1 invalid timing mode
    run(2'd0, 1'b0, 2'd3, 0, 0, 16'h00BF, 16'h00B5);
    chk("R1 bad timing no access", wr_n + rd_n == 0, wr_n + rd_n, 0);
    chk("R1 bad timing err", err == 1'b1 && match == 1'b0, {err, match}, 2'b10);

    // given delays
    cv = VECS[1];
    run(2'd1, 1'b1, 2'd0, 50, 30, 16'h7F9D, 16'h7F21);
    chk("R2 enter wait before first access", first_acc >= 50, first_acc, 50);
    chk("R5 gap between writes", min_gap >= 10, min_gap, 10);
    chk("R4 enter wait before first read", ent_gap >= 50, ent_gap, 50);
    chk("R4 exit wait after reset write", f0_gap >= 30, f0_gap, 30);
    chk("R10 given mode result", match == 1'b1, match, 1);

    // default delays
    cv = VECS[0];
    run(2'd0, 1'b0, 2'd2, 0, 0, 16'h00BF, 16'h00B5);
    chk("R10 default enter delay", first_acc >= 10000, first_acc, 10000);
    chk("R10 default exit delay", f0_gap >= 40, f0_gap, 40);
    chk("R5 default gap", min_gap >= 10, min_gap, 10);
    chk("R10 default mode result", match == 1'b1 && done_cnt == 1, match, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule